// File: doc/BRIEF.md
# Reliability-Ordered Insertion Sorter

This block holds a short list of candidate entries, each made of an unsigned reliability key and a payload: a field symbol and two small position indices. The list is always ordered from the most reliable entry (largest key) down to the least reliable one. An elementary processing step of a non-binary decoder feeds candidates into it one per cycle. The same step takes the best surviving candidates out of the head of the list, one per cycle.

Each slot owns a comparator that tests the incoming key against the key stored in that slot. All comparators work in parallel, so an insertion finds its position and shifts the weaker entries down in a single cycle. A pop removes the head entry. When a pop and an insertion fall in the same cycle, the head leaves and the new entry settles in its sorted position in that cycle. A clear input empties the list at the start of every step. The head entry and the current fill count are visible to the controlling logic at all times.

Top module: `rank_insert_sorter`

## Requirements
- R1: After reset, and after a clear, `fill` is 0 and `head_valid` is 0.
- R2: Valid entries are held in non-increasing key order. `head_key` is the largest key present, and successive pops return keys in non-increasing order.
- R3: The symbol and both indices of an entry stay attached to its key through every shift, and they appear on the `head_*` outputs with that key.
- R4: An entry whose key equals that of an entry already held is placed behind it, so equal keys leave in arrival order.
- R5: A pop without an insertion on a non-empty list removes the head. The next entry becomes the head and `fill` drops by one.
- R6: An insertion together with a pop on a non-empty list leaves `fill` unchanged. The old head is gone and the new entry sits in its sorted place, which is the head if its key exceeds all the remaining keys.
- R7: An insertion without a pop into a full list (`fill` = DEPTH) whose key is strictly greater than the last key drops the last entry. A key that is lower than or equal to the last key is discarded. In both cases `fill` stays at DEPTH.
- R8: A pop on an empty list is ignored. If an insertion comes with it, the insertion acts as a plain insertion.
- R9: A clear wins over an insertion or a pop in the same cycle: the next state is empty.
- R10: An inserted entry is visible on the outputs one clock edge after the insertion is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Empty the list at the next edge |
| ins | input | 1 | Insert the entry on `in_*` |
| pop | input | 1 | Remove the head entry |
| in_key | input | KEY_W | Reliability key of the new entry (unsigned, larger is more reliable) |
| in_sym | input | SYM_W | Field symbol of the new entry |
| in_ia | input | $clog2(DEPTH) | First index of the new entry |
| in_ib | input | $clog2(DEPTH) | Second index of the new entry |
| head_valid | output | 1 | List holds at least one entry |
| head_key | output | KEY_W | Key of the head entry |
| head_sym | output | SYM_W | Symbol of the head entry |
| head_ia | output | $clog2(DEPTH) | First index of the head entry |
| head_ib | output | $clog2(DEPTH) | Second index of the head entry |
| fill | output | $clog2(DEPTH+1) | Number of valid entries |

## Verification
An insertion and a pop can fall in the same cycle, and this is the case where a slip between the shift-up and shift-down paths would show. The bench raises both strobes together: on a list with a weaker head, on a full list, and on an empty list where the pop must be ignored. A reference list kept in the bench predicts the surviving order. After each cycle the bench compares the fill count and the whole head entry, and then drains the list to check every entry behind the head.

// File: rtl/rsort_pkg.sv
package rsort_pkg;

    typedef enum logic [1:0] {
        SEL_KEEP = 2'd0,
        SEL_NEW  = 2'd1,
        SEL_UP   = 2'd2,
        SEL_DOWN = 2'd3
    } slot_sel_e;

    // Source of the next value of one slot. ah_* are the "incoming key goes
    // ahead of this slot" flags of the slot above, this slot and the one below.
    function automatic slot_sel_e slot_choice(
        input logic clr,
        input logic ins,
        input logic pop_eff,
        input logic first,
        input logic ah_prev,
        input logic ah_here,
        input logic ah_next
    );
        if (clr)
            return SEL_KEEP;
        if (ins && pop_eff)
            return (!first && ah_here) ? SEL_KEEP : (ah_next ? SEL_NEW : SEL_DOWN);
        if (ins)
            return (!first && ah_prev) ? SEL_UP : (ah_here ? SEL_NEW : SEL_KEEP);
        if (pop_eff)
            return SEL_DOWN;
        return SEL_KEEP;
    endfunction

endpackage

// File: rtl/rsort_cmp.sv
module rsort_cmp #(
    parameter int KEY_W = 5
) (
    input  logic             slot_valid,
    input  logic [KEY_W-1:0] slot_key,
    input  logic [KEY_W-1:0] new_key,
    output logic             goes_ahead
);
    // Strict compare: an equal key stays behind the stored entry.
    always_comb begin
        goes_ahead = !slot_valid || (new_key > slot_key);
    end
endmodule

// File: rtl/rsort_fill.sv
module rsort_fill #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic [DEPTH-1:0] valid
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr)
            count_d = '0;
        else if (inc && !dec && count_q != CNT_W'(DEPTH))
            count_d = count_q + 1'b1;
        else if (dec && !inc && count_q != '0)
            count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= count_d;
    end

    assign count = count_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_valid
        assign valid[i] = (CNT_W'(i) < count_q);
    end

    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count_q == '0);

    a_r8_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !clr && count_q == '0) |=> count_q == '0);
endmodule

// File: rtl/rank_insert_sorter.sv
module rank_insert_sorter
    import rsort_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int KEY_W = 5,
    parameter int SYM_W = 6,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ins,
    input  logic             pop,
    input  logic [KEY_W-1:0] in_key,
    input  logic [SYM_W-1:0] in_sym,
    input  logic [IDX_W-1:0] in_ia,
    input  logic [IDX_W-1:0] in_ib,
    output logic             head_valid,
    output logic [KEY_W-1:0] head_key,
    output logic [SYM_W-1:0] head_sym,
    output logic [IDX_W-1:0] head_ia,
    output logic [IDX_W-1:0] head_ib,
    output logic [CNT_W-1:0] fill
);
    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [SYM_W-1:0] sym;
        logic [IDX_W-1:0] ia;
        logic [IDX_W-1:0] ib;
    } ent_t;

    ent_t       slot_d [DEPTH];
    ent_t       slot_q [DEPTH];
    ent_t       up_e   [DEPTH];
    ent_t       dn_e   [DEPTH];
    ent_t       new_e;
    slot_sel_e  sel    [DEPTH];
    logic [DEPTH:0]   ahead;
    logic [DEPTH-1:0] valid;
    logic [CNT_W-1:0] count;
    logic             pop_eff;
    logic             full;

    assign new_e   = '{key: in_key, sym: in_sym, ia: in_ia, ib: in_ib};
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_eff = pop && (count != '0);

    rsort_fill #(.DEPTH(DEPTH)) i_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (ins && !pop_eff && !full),
        .dec   (pop_eff && !ins),
        .count (count),
        .valid (valid)
    );

    assign ahead[DEPTH] = 1'b1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rsort_cmp #(.KEY_W(KEY_W)) i_cmp (
            .slot_valid (valid[i]),
            .slot_key   (slot_q[i].key),
            .new_key    (in_key),
            .goes_ahead (ahead[i])
        );

        if (i == 0) begin : g_top
            assign up_e[i] = '0;
            assign sel[i]  = slot_choice(clr, ins, pop_eff, 1'b1, 1'b0,
                                         ahead[i], ahead[i+1]);
        end else begin : g_mid
            assign up_e[i] = slot_q[i-1];
            assign sel[i]  = slot_choice(clr, ins, pop_eff, 1'b0, ahead[i-1],
                                         ahead[i], ahead[i+1]);
        end

        if (i == DEPTH - 1) begin : g_bot
            assign dn_e[i] = '0;
        end else begin : g_low
            assign dn_e[i] = slot_q[i+1];
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            case (sel[i])
                SEL_NEW:  slot_d[i] = new_e;
                SEL_UP:   slot_d[i] = up_e[i];
                SEL_DOWN: slot_d[i] = dn_e[i];
                default:  slot_d[i] = slot_q[i];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                slot_q[i] <= slot_d[i];
        end
    end

    assign head_valid = valid[0];
    assign head_key   = slot_q[0].key;
    assign head_sym   = slot_q[0].sym;
    assign head_ia    = slot_q[0].ia;
    assign head_ib    = slot_q[0].ib;
    assign fill       = count;

    for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_order_chk
        a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
            valid[i+1] |-> slot_q[i].key >= slot_q[i+1].key);
    end

    if (DEPTH > 1) begin : g_pop_chk
        a_r5_pop_shift: assert property (@(posedge clk) disable iff (!rst_n)
            (pop && !ins && !clr && count > CNT_W'(1)) |=>
                (head_key == $past(slot_q[1].key) && fill == $past(count) - 1'b1));
    end

    a_r6_swap_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && ins && !clr && count != '0) |=> fill == $past(count));

    a_r7_weak_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && !pop && !clr && full && in_key <= slot_q[DEPTH-1].key) |=>
            ($stable(head_key) && $stable(head_sym) && fill == CNT_W'(DEPTH)));

    a_r10_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && !clr && count == '0) |=> (head_valid && head_key == $past(in_key)));
endmodule

// File: tb/test_rank_insert_sorter.sv
module test_rank_insert_sorter;
    localparam int D   = 4;
    localparam int KW  = 5;
    localparam int SW  = 6;
    localparam int IW  = 2;
    localparam int CW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0, ins = 1'b0, pop = 1'b0;
    logic [KW-1:0] in_key = '0;
    logic [SW-1:0] in_sym = '0;
    logic [IW-1:0] in_ia = '0, in_ib = '0;
    logic          head_valid;
    logic [KW-1:0] head_key;
    logic [SW-1:0] head_sym;
    logic [IW-1:0] head_ia, head_ib;
    logic [CW-1:0] fill;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int mk [D];
    int ms [D];
    int ma [D];
    int mb [D];
    int mcnt = 0;

    always #4 clk = ~clk;

    rank_insert_sorter #(.DEPTH(D), .KEY_W(KW), .SYM_W(SW)) i_rank_insert_sorter (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ins(ins), .pop(pop),
        .in_key(in_key), .in_sym(in_sym), .in_ia(in_ia), .in_ib(in_ib),
        .head_valid(head_valid), .head_key(head_key), .head_sym(head_sym),
        .head_ia(head_ia), .head_ib(head_ib), .fill(fill)
    );

    task automatic model_step(input bit c, input bit i, input bit p,
                              input int k, input int s, input int a, input int b);
        bit place;
        int pos;
        if (c) begin
            mcnt = 0;
            return;
        end
        if (p && mcnt > 0) begin
            for (int j = 0; j < D - 1; j++) begin
                mk[j] = mk[j+1]; ms[j] = ms[j+1]; ma[j] = ma[j+1]; mb[j] = mb[j+1];
            end
            mcnt--;
        end
        if (!i) return;
        place = 1;
        if (mcnt == D) begin
            if (k > mk[D-1]) mcnt--;
            else place = 0;
        end
        if (!place) return;
        pos = mcnt;
        for (int j = mcnt - 1; j >= 0; j--)
            if (k > mk[j]) pos = j;
        for (int j = mcnt; j > pos; j--) begin
            mk[j] = mk[j-1]; ms[j] = ms[j-1]; ma[j] = ma[j-1]; mb[j] = mb[j-1];
        end
        mk[pos] = k; ms[pos] = s; ma[pos] = a; mb[pos] = b;
        mcnt++;
    endtask

    task automatic check_out(input string tag);
        bit bad;
        checks++;
        bad = (int'(fill) != mcnt) || (head_valid != (mcnt > 0));
        if (mcnt > 0)
            bad = bad || int'(head_key) != mk[0] || int'(head_sym) != ms[0]
                      || int'(head_ia) != ma[0] || int'(head_ib) != mb[0];
        if (bad) begin
            errors++;
            $display("FAIL %s: got fill=%0d v=%0d key=%0d sym=%0d ia=%0d ib=%0d exp fill=%0d key=%0d sym=%0d ia=%0d ib=%0d",
                     tag, fill, head_valid, head_key, head_sym, head_ia, head_ib,
                     mcnt, (mcnt > 0) ? mk[0] : 0, (mcnt > 0) ? ms[0] : 0,
                     (mcnt > 0) ? ma[0] : 0, (mcnt > 0) ? mb[0] : 0);
        end
    endtask

    task automatic do_op(input bit c, input bit i, input bit p, input int k,
                         input int s, input int a, input int b, input string tag);
        @(negedge clk);
        clr = c; ins = i; pop = p;
        in_key = KW'(k); in_sym = SW'(s); in_ia = IW'(a); in_ib = IW'(b);
        @(posedge clk);
        #1;
        model_step(c, i, p, k, s, a, b);
        check_out(tag);
    endtask

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        #1;
        check_out("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        do_op(0, 1, 0, 10, 1, 1, 2, "R10 first insert");
        do_op(0, 1, 0, 20, 2, 0, 1, "R2 stronger becomes head");
        do_op(0, 1, 0, 15, 3, 2, 0, "R3 payload held");
        do_op(0, 1, 0, 20, 4, 3, 3, "R4 tie behind");
        do_op(0, 0, 1, 0, 0, 0, 0, "R5 pop reveals tie");
        do_op(0, 1, 1, 25, 5, 1, 3, "R6 insert+pop new head");
        do_op(0, 1, 0, 12, 6, 2, 2, "R2 fill to full");
        do_op(0, 1, 0, 5, 7, 0, 0, "R7 weak key discarded");
        do_op(0, 1, 0, 10, 8, 1, 1, "R7 equal key discarded");
        do_op(0, 1, 0, 13, 9, 3, 0, "R7 strong key drops last");
        do_op(0, 1, 1, 14, 10, 2, 1, "R6 insert+pop on full");
        for (int j = 0; j < D; j++)
            do_op(0, 0, 1, 0, 0, 0, 0, "R2 drain order");
        do_op(0, 0, 1, 0, 0, 0, 0, "R8 pop empty");
        do_op(0, 1, 1, 7, 11, 1, 0, "R8 pop empty with insert");
        do_op(0, 1, 0, 9, 12, 0, 3, "R3 second entry");
        do_op(1, 1, 1, 30, 13, 2, 2, "R9 clear wins");
        do_op(0, 0, 0, 0, 0, 0, 0, "R1 stays empty");

        seed = 32'h1234;
        for (int n = 0; n < 3000; n++) begin
            bit c, i, p;
            seed = seed * 1103515245 + 12345;
            c = ((seed >>> 20) % 41) == 0;
            i = ((seed >>> 8) & 3) != 0;
            p = ((seed >>> 11) & 3) == 0;
            do_op(c, i, p, (seed >>> 14) & 7, (seed >>> 17) & 63,
                  (seed >>> 24) & 3, (seed >>> 26) & 3, "R2 R3 R4 R6 sweep");
        end

        @(negedge clk);
        clr = 0; ins = 0; pop = 0;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule